// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host move single bytes to and from an external static RAM that has no clock of its own. The memory holds 131,072 bytes behind a 17-bit address and an 8-bit bidirectional data bus. It is selected through two chip enables of opposite sense: an active-low enable and an active-high enable. Two active-low strobes control it, one for output and one for writing.

The host offers an access by raising a request together with the address, the direction and the write byte. The controller accepts the access in a cycle where ready is high. It captures the host fields and then runs a fixed sequence on the memory pins. Each sequence length is a whole number of clock cycles, rounded up from a nanosecond figure at the clock period. A read returns its byte with a one-cycle valid pulse in the same cycle that ready comes back. A write is closed by raising the write strobe while the enables, the address and the data are all held. This respects the rule that setup and hold count from the edge that ends the write.

Top module: `async_sram_ctl`

## Requirements
- R1: Out of reset and whenever idle, the active-low enable is high, the active-high enable is low, both strobes are high, ready is high and read-valid is low.
- R2: After acceptance, ready stays low for exactly RD_CYC+1 cycles for a read and WR_CYC+1 cycles for a write. The memory address does not change while the memory is selected.
- R3: A read holds the output strobe low, both enables asserted and the write strobe high for RD_CYC+1 cycles, where RD_CYC = ceil(T_AA_NS / CLK_PERIOD_NS) with a minimum of 1. Read-valid is then high for one cycle, together with the returning ready, and the read byte is on the read-data output during that cycle.
- R4: A write holds the write strobe low for exactly WR_CYC cycles, where WR_CYC is the larger of ceil(T_PWE_NS / CLK_PERIOD_NS) and ceil(T_SD_NS / CLK_PERIOD_NS), each at least 1. The write strobe is low only while the memory is selected.
- R5: A write ends on the rising write strobe. In that cycle both enables are still asserted and the data bus still carries the same byte the controller drove during the strobe.
- R6: The controller drives the data bus only during the write strobe and the one cycle after it, and never while the output strobe is low.
- R7: Each access selects the memory for one unbroken interval of its own length. At least one deselected cycle separates consecutive accesses, even when the request is held high.
- R8: A request raised and dropped while ready is low starts no access.
- R9: A read returns the byte most recently written to that address, including addresses 0 and 17'h1FFFF.
- R10: The write strobe and the output strobe are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Access request, taken when hostReady is high |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 17 | Byte address |
| hostWdata | input | 8 | Byte to write |
| hostReady | output | 1 | High when a request can be accepted |
| hostRdata | output | 8 | Byte returned by the last read |
| hostRvalid | output | 1 | One-cycle pulse marking hostRdata valid |
| memAddr | output | 17 | Memory address |
| memCe1N | output | 1 | Active-low chip enable |
| memCe2 | output | 1 | Active-high chip enable |
| memOeN | output | 1 | Active-low output strobe |
| memWeN | output | 1 | Active-low write strobe |
| memDq | inout | 8 | Bidirectional memory data bus |

## Verification
The assertions assume that the memory drives the data bus only while it is selected with the output strobe low and the write strobe high. They also assume that the host keeps its request fields steady from raising the request until the accepting edge. The bench's behavioural memory drives the bus only under that exact decode. Every request is set up at a falling edge and held until ready has been seen high, so no field changes inside an accepting cycle. Held-request and busy-request cases still stay within these assumptions, because acceptance is decided only at the controller's own ready.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_ACC = 3'd1,
    ST_RD_CAP = 3'd2,
    ST_WR_STB = 3'd3,
    ST_WR_END = 3'd4
  } ctlState_t;

  // memory pin image, registered as one word in the control
  typedef struct packed {
    logic ce1N;
    logic ce2;
    logic oeN;
    logic weN;
    logic drive;
  } memPins_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic capture;
    logic driveEn;
  } dpStrobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic memPins_t pinsFor(input ctlState_t s);
    memPins_t p;
    p = '{ce1N: 1'b1, ce2: 1'b0, oeN: 1'b1, weN: 1'b1, drive: 1'b0};
    case (s)
      ST_RD_ACC, ST_RD_CAP: begin
        p.ce1N = 1'b0; p.ce2 = 1'b1; p.oeN = 1'b0;
      end
      ST_WR_STB: begin
        p.ce1N = 1'b0; p.ce2 = 1'b1; p.weN = 1'b0; p.drive = 1'b1;
      end
      ST_WR_END: begin
        p.ce1N = 1'b0; p.ce2 = 1'b1; p.drive = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC = 1,
  parameter int WR_CYC = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      req,
  input  logic      isWrite,
  output logic      ready,
  output memPins_t  pinsQ,
  output dpStrobe_t strobe
);
  localparam int MAXC  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CNT_W = $clog2(MAXC + 1) + 1;

  ctlState_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic accept, capture;

  always_comb begin
    stateD  = stateQ;
    cntD    = cntQ;
    accept  = 1'b0;
    capture = 1'b0;
    case (stateQ)
      ST_IDLE: if (req) begin
        accept = 1'b1;
        cntD   = '0;
        stateD = isWrite ? ST_WR_STB : ST_RD_ACC;
      end
      ST_RD_ACC: begin
        if (cntQ == CNT_W'(RD_CYC - 1)) begin
          stateD = ST_RD_CAP;
          cntD   = '0;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_RD_CAP: begin
        capture = 1'b1;
        stateD  = ST_IDLE;
      end
      ST_WR_STB: begin
        if (cntQ == CNT_W'(WR_CYC - 1)) begin
          stateD = ST_WR_END;
          cntD   = '0;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_WR_END: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      pinsQ  <= pinsFor(ST_IDLE);
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      pinsQ  <= pinsFor(stateD);
    end
  end

  assign ready           = (stateQ == ST_IDLE);
  assign strobe.latchReq = accept;
  assign strobe.capture  = capture;
  assign strobe.driveEn  = pinsQ.drive;

  // consecutive cycles with write strobe low, for the pulse-width check
  logic [CNT_W-1:0] weRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            weRun <= '0;
    else if (!pinsQ.weN)  weRun <= weRun + 1'b1;
    else                  weRun <= '0;
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (pinsQ.ce1N && !pinsQ.ce2 && pinsQ.oeN && pinsQ.weN)); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !ready); // R2
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinsQ.weN) |-> (weRun == CNT_W'(WR_CYC))); // R4
  AST_WE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !pinsQ.weN |-> (!pinsQ.ce1N && pinsQ.ce2)); // R4
  AST_WE_RISE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinsQ.weN) |-> (!pinsQ.ce1N && pinsQ.ce2 && pinsQ.drive)); // R5
  AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    pinsQ.drive |-> pinsQ.oeN); // R6
  AST_GAP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinsQ.ce1N) |-> ready); // R7
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!pinsQ.weN && !pinsQ.oeN)); // R10

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              rvalidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobe.latchReq) begin
      addrQ  <= hostAddr;
      wdataQ <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ  <= '0;
      rvalidQ <= 1'b0;
    end else begin
      rvalidQ <= strobe.capture;
      if (strobe.capture) rdataQ <= memDqIn;
    end
  end

  assign memAddr = addrQ;
  assign wrData  = wdataQ;
  assign rdData  = rdataQ;
  assign rdValid = rvalidQ;

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rvalidQ |=> !rvalidQ); // R3
  AST_WDATA_HELD_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.driveEn && $past(strobe.driveEn)) |-> $stable(wdataQ)); // R5

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_AA_NS       = 20,
  parameter int T_PWE_NS      = 15,
  parameter int T_SD_NS       = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostReady,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  inout  wire  [DATA_W-1:0] memDq
);
  localparam int RD_CYC  = nsToCycles(T_AA_NS, CLK_PERIOD_NS);
  localparam int PWE_CYC = nsToCycles(T_PWE_NS, CLK_PERIOD_NS);
  localparam int SD_CYC  = nsToCycles(T_SD_NS, CLK_PERIOD_NS);
  localparam int WR_CYC  = (PWE_CYC > SD_CYC) ? PWE_CYC : SD_CYC;

  memPins_t          pins;
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] wrData;

  sram_ctl_fsm #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) ctl_i (
    .clk(clk), .rstN(rstN), .req(hostReq), .isWrite(hostWrite),
    .ready(hostReady), .pinsQ(pins), .strobe(strobe)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .memDqIn(memDq), .memAddr(memAddr),
    .wrData(wrData), .rdData(hostRdata), .rdValid(hostRvalid)
  );

  assign memCe1N = pins.ce1N;
  assign memCe2  = pins.ce2;
  assign memOeN  = pins.oeN;
  assign memWeN  = pins.weN;
  assign memDq   = strobe.driveEn ? wrData : {DATA_W{1'bz}};

  AST_ADDR_HELD_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (!memCe1N && $past(!memCe1N)) |-> $stable(memAddr)); // R2

endmodule

// File: tb/async_sram_ctl_tb_top.sv
module async_sram_ctl_tb_top;
  localparam int PERIOD = 20;
  localparam int T_AA   = 45;
  localparam int T_PWE  = 35;
  localparam int T_SD   = 10;
  localparam int RD_EXP = (T_AA + PERIOD - 1) / PERIOD;
  localparam int PW_EXP = (T_PWE + PERIOD - 1) / PERIOD;
  localparam int SD_EXP = (T_SD + PERIOD - 1) / PERIOD;
  localparam int WR_EXP = (PW_EXP > SD_EXP) ? PW_EXP : SD_EXP;
  localparam int NVEC = 8;
  localparam logic [24:0] VEC [NVEC] = '{
    {17'h00000, 8'hA5}, {17'h1FFFF, 8'h3C}, {17'h00001, 8'hFF},
    {17'h10000, 8'h00}, {17'h0ABCD, 8'h96}, {17'h15555, 8'h5A},
    {17'h0AAAA, 8'hC3}, {17'h1FFFE, 8'h81}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReq = 1'b0, hostWrite = 1'b0;
  logic [16:0] hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic hostReady, hostRvalid;
  logic [7:0] hostRdata;
  logic [16:0] memAddr;
  logic memCe1N, memCe2, memOeN, memWeN;
  wire  [7:0] memDq;

  int nCompared = 0, nMismatch = 0;
  int nWrites = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  async_sram_ctl #(.CLK_PERIOD_NS(PERIOD), .T_AA_NS(T_AA), .T_PWE_NS(T_PWE),
                   .T_SD_NS(T_SD)) dut_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostReady(hostReady),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memDq(memDq)
  );

  // behavioural memory
  logic [7:0] model [logic [16:0]];
  logic [7:0] modelData = 8'h00;
  logic modelDrive;
  assign modelDrive = !memCe1N && memCe2 && !memOeN && memWeN;
  assign memDq = modelDrive ? modelData : 8'bz;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor on the memory pins
  int weRun = 0, oeRun = 0, selRun = 0;
  bit prevWe = 1'b1, prevOe = 1'b1, prevSel = 1'b0, runWrite = 1'b0;
  logic [7:0] lastDq = 8'h00;
  always @(negedge clk) begin
    bit sel;
    sel = !memCe1N && memCe2;
    if (sel && !memOeN && memWeN)
      modelData = model.exists(memAddr) ? model[memAddr] : 8'h00;
    #1;
    if (monOn) begin
      if (!memWeN && !memOeN) check(0, "R10 strobes both low", 1, 0);
      if (!memWeN && !sel) check(0, "R4 strobe while deselected", 0, 1);
      if (modelDrive) check(memDq === modelData, "R6 bus contention", memDq, modelData);
      if (!memWeN) begin
        weRun++;
        lastDq = memDq;
        runWrite = 1'b1;
      end
      if (!prevWe && memWeN) begin
        check(weRun == WR_EXP, "R4 strobe length", weRun, WR_EXP);
        check(sel && memDq === lastDq, "R5 write end held", memDq, lastDq);
        model[memAddr] = memDq;
        nWrites++;
        weRun = 0;
      end
      if (!memOeN) oeRun++;
      if (!prevOe && memOeN) begin
        check(oeRun == RD_EXP + 1, "R3 output strobe length", oeRun, RD_EXP + 1);
        oeRun = 0;
      end
      if (sel) selRun++;
      if (prevSel && !sel) begin
        check(selRun == (runWrite ? WR_EXP + 1 : RD_EXP + 1), "R7 select interval",
              selRun, runWrite ? WR_EXP + 1 : RD_EXP + 1);
        selRun = 0;
        runWrite = 1'b0;
      end
    end
    prevWe = memWeN;
    prevOe = memOeN;
    prevSel = sel;
  end

  task automatic doOp(input bit wr, input logic [16:0] a, input logic [7:0] d,
                      output logic [7:0] q);
    int busy;
    busy = 0;
    q = 8'h00;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d;
    while (!hostReady) @(negedge clk);
    @(negedge clk);
    hostReq = 1'b0;
    while (!hostReady) begin
      busy++;
      @(negedge clk);
    end
    check(busy == (wr ? WR_EXP : RD_EXP) + 1, "R2 busy length", busy,
          (wr ? WR_EXP : RD_EXP) + 1);
    if (!wr) begin
      check(hostRvalid === 1'b1, "R3 valid with ready", hostRvalid, 1);
      q = hostRdata;
      @(negedge clk);
      check(hostRvalid === 1'b0, "R3 valid one cycle", hostRvalid, 0);
    end else begin
      check(hostRvalid === 1'b0, "R3 no valid on write", hostRvalid, 0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nMismatch++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int w0;
    repeat (3) @(negedge clk);
    check(memCe1N && !memCe2 && memOeN && memWeN, "R1 pins in reset",
          {memCe1N, memCe2, memOeN, memWeN}, 4'b1011);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;
    check(hostReady === 1'b1 && hostRvalid === 1'b0, "R1 host side after reset",
          {hostReady, hostRvalid}, 2'b10);
    check(memCe1N && !memCe2 && memOeN && memWeN, "R1 pins idle",
          {memCe1N, memCe2, memOeN, memWeN}, 4'b1011);

    // vector table: write all, then read back (R9)
    for (int i = 0; i < NVEC; i++) doOp(1'b1, VEC[i][24:8], VEC[i][7:0], q);
    for (int i = 0; i < NVEC; i++) begin
      doOp(1'b0, VEC[i][24:8], 8'h00, q);
      check(q === VEC[i][7:0], "R9 readback", q, VEC[i][7:0]);
    end

    // overwrite then read at the top address
    doOp(1'b1, 17'h1FFFF, 8'h7E, q);
    doOp(1'b0, 17'h1FFFF, 8'h00, q);
    check(q === 8'h7E, "R9 overwrite top address", q, 8'h7E);

    // R8: request pulsed while busy is ignored
    w0 = nWrites;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 17'h00000;
    @(negedge clk);
    hostReq = 1'b0;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 17'h00000; hostWdata = 8'h11;
    @(negedge clk);
    hostReq = 1'b0;
    check(hostReady === 1'b0, "R8 pulse landed while busy", hostReady, 0);
    while (!hostReady) @(negedge clk);
    repeat (3) @(negedge clk);
    check(nWrites == w0, "R8 no write started", nWrites, w0);
    doOp(1'b0, 17'h00000, 8'h00, q);
    check(q === 8'hA5, "R8 location untouched", q, 8'hA5);

    // R7: request held high for several back-to-back writes
    w0 = nWrites;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 17'h00420; hostWdata = 8'h42;
    repeat (4 * (WR_EXP + 2)) @(negedge clk);
    hostReq = 1'b0;
    while (!hostReady) @(negedge clk);
    repeat (2) @(negedge clk);
    check(nWrites - w0 >= 3, "R7 held request gives separate writes", nWrites - w0, 3);
    check(memCe1N && !memCe2, "R7 deselected after burst of requests",
          {memCe1N, memCe2}, 2'b10);
    doOp(1'b0, 17'h00420, 8'h00, q);
    check(q === 8'h42, "R9 readback after held request", q, 8'h42);

    // R6: write driven value visible on the bus during the strobe
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 17'h00777; hostWdata = 8'hE7;
    @(negedge clk);
    hostReq = 1'b0;
    check(!memWeN && memOeN && memDq === 8'hE7, "R6 bus driven in strobe",
          memDq, 8'hE7);
    while (!hostReady) @(negedge clk);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule